// File: doc/BRIEF.md
# Entropy Data Register with Refill

This block holds one word of random data that an external entropy source fills over a valid/ready stream. Software reads the word through a simple register read port. A second register reports whether the word is valid and carries a quality flag that came with it. When software reads a valid word, the read consumes it. The word is cleared, marked invalid, and the block asks the source for a new one on its own. An invalid word reads as zero.

The stream input uses the block's ready output as the refill request. The source may raise its valid at any time. A transfer happens only on a rising clock edge where both valid and ready are high. While ready is low the block applies back-pressure: the source must hold its word, and valid has no effect. Ready stays high from reset, or from the moment a word is consumed, until one transfer completes. For that reason at most one request is ever outstanding.

Register map (byte offsets, parameterised): the data word is at 0x0 and the status word is at 0x4. Status bit 0 is the valid flag and status bit 1 is the quality flag. Every other address reads as zero.

Top module: `rnd_pool_reg`

## Requirements
- R1: After reset the word is invalid, ent_ready_o is 1, and reads of the data register (offset 0x0) and the status register (offset 0x4) both return 0.
- R2: While the word is invalid, the data register reads 0x0 and status bit 0 reads 0.
- R3: ent_ready_o stays 1 until a cycle with ent_valid_i high. ent_data_i is captured at that edge. From the next cycle ent_ready_o is 0 and status bit 0 is 1.
- R4: While ent_ready_o is 0, ent_valid_i and ent_data_i have no effect on the stored word or on the status register.
- R5: A read strobe (rd_en_i=1) at offset 0x0 while the word is valid returns the word in that same cycle. From the next cycle the word is invalid, the data register reads 0, and ent_ready_o is 1.
- R6: A read strobe at offset 0x0 while the word is invalid returns 0 and changes nothing. ent_ready_o stays 1 and no second request is started.
- R7: Status bit 1 holds the ent_qual_i value captured with the word. It is cleared to 0 when the word is consumed.
- R8: Read strobes at the status offset or at any unmapped offset do not consume the word. Unmapped offsets read 0.
- R9: An address of 0x0 presented with rd_en_i low does not consume the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_i | input | ADDR_W (4) | Byte offset of the register read |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | DATA_W (32) | Read data for rd_addr_i, combinational |
| ent_ready_o | output | 1 | Refill request; stream ready |
| ent_valid_i | input | 1 | Stream valid from the entropy source |
| ent_data_i | input | DATA_W (32) | Entropy word |
| ent_qual_i | input | 1 | Quality flag that travels with the word |

## Verification
The hardest situation to reach is a source that keeps valid high while the block is full. That is the only time the back-pressure rule is tested. The bench holds ent_valid_i high with a different word in the cycles after each capture, then reads the word back to show it did not change. Each round also sweeps every address with a strobe and applies an unstrobed data address before the consuming read. Refill delays vary from round to round, and the word patterns include all-zero and all-one values.

// File: rtl/rnd_pool_pkg.sv
package rnd_pool_pkg;
  localparam int unsigned STAT_VALID_BIT = 0;
  localparam int unsigned STAT_QUAL_BIT  = 1;
  localparam int unsigned STAT_BITS      = 2;

  typedef struct packed {
    logic qual;
    logic valid;
  } rnd_stat_t;
endpackage

// File: rtl/rnd_refill.sv
module rnd_refill #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume_i,
  input  logic              ent_valid_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic              ent_qual_i,
  output logic              ent_ready_o,
  output logic [DATA_W-1:0] word_o,
  output rnd_pool_pkg::rnd_stat_t stat_o
);
  logic              req_q;
  logic              valid_q;
  logic              qual_q;
  logic [DATA_W-1:0] word_q;
  logic              xfer;
  logic              take;

  assign xfer = req_q && ent_valid_i;
  assign take = consume_i && valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b1;
      valid_q <= 1'b0;
      qual_q  <= 1'b0;
      word_q  <= '0;
    end else if (xfer) begin
      req_q   <= 1'b0;
      valid_q <= 1'b1;
      qual_q  <= ent_qual_i;
      word_q  <= ent_data_i;
    end else if (take) begin
      req_q   <= 1'b1;
      valid_q <= 1'b0;
      qual_q  <= 1'b0;
      word_q  <= '0;
    end
  end

  assign ent_ready_o  = req_q;
  assign word_o       = word_q;
  assign stat_o.valid = valid_q;
  assign stat_o.qual  = qual_q;

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q != valid_q);
  assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ent_valid_i) |=> req_q);
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (!req_q && valid_q && word_q == $past(ent_data_i)));
  assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !consume_i) |=> ($stable(word_q) && $stable(qual_q) && valid_q));
  assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (req_q && !valid_q && word_q == '0 && !qual_q));
endmodule

// File: rtl/rnd_regread.sv
module rnd_regread #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DATA_OFF = 0,
  parameter int unsigned STAT_OFF = 4
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] word_i,
  input  rnd_pool_pkg::rnd_stat_t stat_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              consume_o
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFF);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  logic [DATA_W-1:0] stat_word;
  logic              hit_data;
  logic              hit_stat;

  always_comb begin
    stat_word = '0;
    stat_word[rnd_pool_pkg::STAT_VALID_BIT] = stat_i.valid;
    stat_word[rnd_pool_pkg::STAT_QUAL_BIT]  = stat_i.qual;
  end

  assign hit_data  = (rd_addr_i == DATA_A);
  assign hit_stat  = (rd_addr_i == STAT_A);
  assign consume_o = rd_en_i && hit_data;

  always_comb begin
    rd_data_o = '0;
    if (hit_data)      rd_data_o = stat_i.valid ? word_i : '0;
    else if (hit_stat) rd_data_o = stat_word;
  end

  always_comb begin
    if (hit_data && !stat_i.valid)
      assert_invalid_reads_zero_R2: assert (rd_data_o == '0);
    if (!hit_data && !hit_stat)
      assert_unmapped_zero_R8: assert (rd_data_o == '0);
  end
endmodule

// File: rtl/rnd_pool_reg.sv
module rnd_pool_reg #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DATA_OFF = 0,
  parameter int unsigned STAT_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ent_ready_o,
  input  logic              ent_valid_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic              ent_qual_i
);
  logic                    consume;
  logic [DATA_W-1:0]       word;
  rnd_pool_pkg::rnd_stat_t stat;

  rnd_refill #(.DATA_W(DATA_W)) u_refill (
    .clk         (clk),
    .rst_n       (rst_n),
    .consume_i   (consume),
    .ent_valid_i (ent_valid_i),
    .ent_data_i  (ent_data_i),
    .ent_qual_i  (ent_qual_i),
    .ent_ready_o (ent_ready_o),
    .word_o      (word),
    .stat_o      (stat)
  );

  rnd_regread #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DATA_OFF (DATA_OFF),
    .STAT_OFF (STAT_OFF)
  ) u_regread (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .word_i    (word),
    .stat_i    (stat),
    .rd_data_o (rd_data_o),
    .consume_o (consume)
  );

  assert_no_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && stat.valid) |=> stat.valid);
  assert_status_read_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i != ADDR_W'(DATA_OFF) && stat.valid) |=> stat.valid);
endmodule

// File: tb/rnd_pool_reg_test.sv
module rnd_pool_reg_test;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic          rd_en_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic          ent_ready_o;
  logic          ent_valid_i = 1'b0;
  logic [DW-1:0] ent_data_i = '0;
  logic          ent_qual_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rnd_pool_reg uut (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(rd_addr_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .ent_ready_o(ent_ready_o), .ent_valid_i(ent_valid_i),
    .ent_data_i(ent_data_i), .ent_qual_i(ent_qual_i)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int i);
    if (i == 0) return 32'h0000_0000;
    if (i == 1) return 32'hFFFF_FFFF;
    return (32'h1357_9BDF * i) ^ (32'(i) << 27);
  endfunction

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en_i = 1'b0; rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic strobe(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = a;
    #1 d = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] w;
    logic          q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ready after reset", 32'(ent_ready_o), 32'd1);
    peek(4'h0, d); chk("R1 data after reset", d, 32'd0);
    peek(4'h4, d); chk("R1 status after reset", d, 32'd0);
    for (int k = 0; k < 3; k++) begin
      strobe(4'h0, d);
      chk("R6 invalid read returns zero", d, 32'd0);
      chk("R6 request stays single", 32'(ent_ready_o), 32'd1);
      peek(4'h4, d); chk("R2 status valid low", d, 32'd0);
    end
    for (int i = 0; i < 12; i++) begin
      w = word_of(i);
      q = i[0] ^ i[2];
      for (int k = 0; k < i % 4; k++) begin
        @(negedge clk);
        #1 chk("R3 request held until ack", 32'(ent_ready_o), 32'd1);
      end
      peek(4'h0, d); chk("R2 invalid data reads zero", d, 32'd0);
      @(negedge clk);
      ent_valid_i = 1'b1; ent_data_i = w; ent_qual_i = q;
      @(negedge clk);
      ent_data_i = ~w; ent_qual_i = ~q;
      #1 chk("R3 request drops after ack", 32'(ent_ready_o), 32'd0);
      repeat (2) @(negedge clk);
      ent_valid_i = 1'b0;
      peek(4'h4, d); chk("R7 status after capture", d, {30'd0, q, 1'b1});
      peek(4'h0, d); chk("R4 word unchanged under back-pressure", d, w);
      for (int a = 1; a < 16; a++) begin
        strobe(4'(a), d);
        if (a == 4) chk("R8 status read", d, {30'd0, q, 1'b1});
        else        chk("R8 unmapped reads zero", d, 32'd0);
      end
      peek(4'h0, d); chk("R9 unstrobed address keeps word", d, w);
      peek(4'h0, d); chk("R8 R9 word still present", d, w);
      strobe(4'h0, d); chk("R5 consuming read returns word", d, w);
      chk("R5 request raised after read", 32'(ent_ready_o), 32'd1);
      peek(4'h0, d); chk("R5 data zero after read", d, 32'd0);
      peek(4'h4, d); chk("R7 status cleared after read", d, 32'd0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule